// File: doc/BRIEF.md
# Parity-Checked Mesh Switch Datapath

This block is the datapath slice of one input port in a mesh network switch whose links carry a single even-parity bit beside each 64-bit flit. The parity of an arriving flit is recomputed right at the port. A mismatch means the fault lies on the incoming link. Such a flit is refused on the spot: it is never written into the stage register, never routed, and the upstream hop sees a reject response.

A flit that passes the input check goes through a dimension-order router, X first and then Y, into a one-entry output stage. Its parity travels with it. At the output the parity of the stored flit is computed again and compared with the bit that arrived on the link. A mismatch there can only come from corruption inside the switch, so a separate switch error flag is raised. Because of this split, a fault handler can tell a bad link from a bad switch. Both flags hold their value until they are cleared.

A head flit names its destination in two 2-bit coordinate fields. The route it selects is latched, and the body and tail flits that follow reuse that latched route. The `dp_upset` input is XORed onto the flit between the input check and the stage register. It stands for an upset inside the switch.

Top module: `cdp_switch_dp`

## Requirements
- R1: Parity is even: a flit is corrupt when the XOR of its 64 bits differs from `in_par`. A corrupt flit presented with `in_valid` sets `link_err` at the next clock edge.
- R2: After each clock edge at which `in_valid` was high, `resp_valid` is high for one cycle. `resp_ok` is then 1 if the flit passed the input check and 0 if it failed. When no flit was presented, `resp_valid` is 0.
- R3: A corrupt flit is dropped. `out_valid` is all zero in the following cycle, `out_flit`/`out_par` keep their previous values, and the latched route is left unchanged.
- R4: A clean flit appears one cycle later on exactly one `out_valid` bit. `out_flit` equals `in_flit ^ dp_upset`, and `out_par` equals the received `in_par`.
- R5: A flit with bit 62 set is a head. Its destination X is in bits [1:0] and its destination Y in bits [3:2]. The head is routed X first: destination X greater than the own X selects East (`out_valid` bit 1), and smaller selects West (bit 2). Otherwise destination Y greater than the own Y selects North (bit 3), smaller selects South (bit 4), and equal selects Local (bit 0).
- R6: A flit with bit 62 clear follows the route latched from the last head that passed the input check. After reset that route is Local.
- R7: When a valid output flit's parity differs from its carried parity bit, `switch_err` is set at the next edge. For a flit presented in cycle t, that is visible in cycle t+2. `link_err` is not affected.
- R8: Both flags are sticky. A cycle with `err_clr` high clears them at the next edge, unless a new error sets that flag at the same edge; setting wins.
- R9: After reset, `link_err`, `switch_err`, `resp_valid` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present on the link |
| in_flit | input | 64 | Incoming flit |
| in_par | input | 1 | Even-parity bit received with the flit |
| dp_upset | input | 64 | Bit flips applied inside the switch after the input check |
| err_clr | input | 1 | Clears both sticky error flags |
| resp_valid | output | 1 | Response to the upstream hop is valid |
| resp_ok | output | 1 | 1 = flit accepted, 0 = rejected (NACK) |
| out_valid | output | 5 | One-hot output port select: Local, East, West, North, South |
| out_flit | output | 64 | Routed flit |
| out_par | output | 1 | Parity bit carried from the input |
| link_err | output | 1 | Sticky link fault flag |
| switch_err | output | 1 | Sticky internal switch fault flag |

## Verification
Random flits with random head markers and destinations cover all five route choices. Body flits in the same stream show whether the latched route is followed rather than recomputed. Flits with a flipped parity bit separate the link-fault path from the normal path: they must produce a reject, leave the outputs and route latch untouched, and raise only the link flag. Single-bit upsets on clean flits raise only the switch flag, two cycles later. Directed sequences cover a corrupt head followed by a body flit, and a clear that arrives in the same cycle as a fresh error.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int NPORT   = 5;
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;
endpackage

// File: rtl/cdp_par_gen.sv
module cdp_par_gen #(
    parameter int W = 64
) (
    input  logic [W-1:0] d,
    output logic         p
);
    localparam int HALF = W / 2;
    generate
        if (W > 8) begin : g_split
            logic p_lo, p_hi;
            cdp_par_gen #(.W(HALF))     u_lo (.d(d[HALF-1:0]), .p(p_lo));
            cdp_par_gen #(.W(W - HALF)) u_hi (.d(d[W-1:HALF]), .p(p_hi));
            assign p = p_lo ^ p_hi;
        end else begin : g_leaf
            assign p = ^d;
        end
    endgenerate
endmodule

// File: rtl/cdp_xy_route.sv
module cdp_xy_route
    import cdp_pkg::*;
#(
    parameter int CW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 2
) (
    input  logic [CW-1:0]    dst_x,
    input  logic [CW-1:0]    dst_y,
    output logic [NPORT-1:0] sel
);
    localparam logic [CW-1:0] OWN_X = CW'(MY_X);
    localparam logic [CW-1:0] OWN_Y = CW'(MY_Y);

    always_comb begin
        sel = '0;
        if (dst_x > OWN_X)      sel[P_EAST]  = 1'b1;
        else if (dst_x < OWN_X) sel[P_WEST]  = 1'b1;
        else if (dst_y > OWN_Y) sel[P_NORTH] = 1'b1;
        else if (dst_y < OWN_Y) sel[P_SOUTH] = 1'b1;
        else                    sel[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/cdp_switch_dp.sv
module cdp_switch_dp
    import cdp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_flit,
    input  logic              in_par,
    input  logic [DATA_W-1:0] dp_upset,
    input  logic              err_clr,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [NPORT-1:0]  out_valid,
    output logic [DATA_W-1:0] out_flit,
    output logic              out_par,
    output logic              link_err,
    output logic              switch_err
);
    localparam int CW       = (MESH_X > MESH_Y) ? $clog2(MESH_X) : $clog2(MESH_Y);
    localparam int HEAD_BIT = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] flit;
        logic              par;
        logic [NPORT-1:0]  vld;
        logic [NPORT-1:0]  route;
        logic              resp_v;
        logic              resp_ok;
        logic              lef;
        logic              sef;
    } state_t;

    state_t st_d, st_q;

    logic             in_calc_par;
    logic             out_calc_par;
    logic             link_bad;
    logic             is_head;
    logic [NPORT-1:0] head_sel;
    logic [NPORT-1:0] use_sel;

    cdp_par_gen #(.W(DATA_W)) u_in_par (.d(in_flit), .p(in_calc_par));
    cdp_par_gen #(.W(DATA_W)) u_out_par (.d(st_q.flit), .p(out_calc_par));

    cdp_xy_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dst_x (in_flit[CW-1:0]),
        .dst_y (in_flit[2*CW-1:CW]),
        .sel   (head_sel)
    );

    always_comb begin
        link_bad = in_valid && (in_calc_par != in_par);
        is_head  = in_flit[HEAD_BIT];
        use_sel  = is_head ? head_sel : st_q.route;

        st_d         = st_q;
        st_d.resp_v  = in_valid;
        st_d.resp_ok = in_valid && !link_bad;
        st_d.vld     = '0;
        st_d.lef     = (st_q.lef && !err_clr) || link_bad;
        st_d.sef     = (st_q.sef && !err_clr) ||
                       ((|st_q.vld) && (out_calc_par != st_q.par));
        if (in_valid && !link_bad) begin
            st_d.flit = in_flit ^ dp_upset;
            st_d.par  = in_par;
            st_d.vld  = use_sel;
            if (is_head) st_d.route = head_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.route <= NPORT'(1) << P_LOCAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.resp_v;
    assign resp_ok    = st_q.resp_ok;
    assign out_valid  = st_q.vld;
    assign out_flit   = st_q.flit;
    assign out_par    = st_q.par;
    assign link_err   = st_q.lef;
    assign switch_err = st_q.sef;

    AST_LINK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        link_bad |=> (link_err && resp_valid && !resp_ok)); // R1
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !resp_valid); // R2
    AST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        link_bad |=> (out_valid == '0 && $stable(out_flit))); // R3
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid)); // R4
    AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !link_bad && dp_upset == '0) |=>
        ($countones(out_valid) == 1 && out_flit == $past(in_flit))); // R4
    AST_SW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && ((^out_flit) != out_par)) |=> switch_err); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_err && !err_clr) |=> link_err); // R8
endmodule

// File: tb/cdp_switch_dp_test.sv
`timescale 1ns/1ps
module cdp_switch_dp_test;
    localparam int DW = 64;
    localparam int NP = 5;
    localparam int MX = 1;
    localparam int MY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_flit = '0;
    logic          in_par = 1'b0;
    logic [DW-1:0] dp_upset = '0;
    logic          err_clr = 1'b0;
    logic          resp_valid, resp_ok, out_par, link_err, switch_err;
    logic [NP-1:0] out_valid;
    logic [DW-1:0] out_flit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [NP-1:0] m_route, m_vld;
    logic [DW-1:0] m_flit;
    logic          m_par, m_rv, m_rok, m_lef, m_sef, m_sv, m_sbad, m_head;

    always #2 clk = ~clk;

    cdp_switch_dp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_par(in_par), .dp_upset(dp_upset), .err_clr(err_clr),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .out_valid(out_valid),
        .out_flit(out_flit), .out_par(out_par), .link_err(link_err),
        .switch_err(switch_err)
    );

    function automatic logic [NP-1:0] xy_fn(input logic [1:0] dx, input logic [1:0] dy);
        if (int'(dx) > MX) return 5'b00010;
        if (int'(dx) < MX) return 5'b00100;
        if (int'(dy) > MY) return 5'b01000;
        if (int'(dy) < MY) return 5'b10000;
        return 5'b00001;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [DW-1:0] f, input bit bad_par,
                         input logic [DW-1:0] up, input bit clr);
        logic          p;
        logic          bad, ok;
        logic [NP-1:0] rt;
        p = (^f) ^ bad_par;
        in_valid = v; in_flit = f; in_par = p; dp_upset = up; err_clr = clr;
        bad = v && bad_par;
        ok  = v && !bad_par;
        m_sef  = (m_sef && !clr) || (m_sv && m_sbad);
        m_lef  = (m_lef && !clr) || bad;
        m_rv   = v;
        m_rok  = ok;
        m_head = f[62];
        rt = f[62] ? xy_fn(f[1:0], f[3:2]) : m_route;
        if (ok && f[62]) m_route = rt;
        m_vld  = ok ? rt : '0;
        if (ok) begin
            m_flit = f ^ up;
            m_par  = p;
        end
        m_sv   = ok;
        m_sbad = ok && (^up);
        @(negedge clk);
        check(resp_valid == m_rv, "R2 resp_valid", DW'(resp_valid), DW'(m_rv));
        if (m_rv) check(resp_ok == m_rok, "R2 resp_ok", DW'(resp_ok), DW'(m_rok));
        check(link_err == m_lef, "R1/R8 link_err", DW'(link_err), DW'(m_lef));
        check(switch_err == m_sef, "R7/R8 switch_err", DW'(switch_err), DW'(m_sef));
        if (bad)
            check(out_valid == '0, "R3 drop out_valid", DW'(out_valid), '0);
        else if (m_head)
            check(out_valid == m_vld, "R5 head route", DW'(out_valid), DW'(m_vld));
        else
            check(out_valid == m_vld, "R6 body route", DW'(out_valid), DW'(m_vld));
        if (m_sv) begin
            check(out_flit == m_flit, "R4 out_flit", out_flit, m_flit);
            check(out_par == m_par, "R4 out_par", DW'(out_par), DW'(m_par));
        end else begin
            check(out_flit == m_flit, "R3 flit not stored", out_flit, m_flit);
        end
    endtask

    function automatic logic [DW-1:0] mk(input bit head, input int dx, input int dy);
        logic [DW-1:0] f;
        f = {$urandom, $urandom};
        f[62]  = head;
        f[1:0] = 2'(dx);
        f[3:2] = 2'(dy);
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        m_route = 5'b00001; m_flit = '0; m_par = 0; m_rv = 0; m_rok = 0;
        m_lef = 0; m_sef = 0; m_sv = 0; m_sbad = 0; m_vld = '0; m_head = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(link_err == 0 && switch_err == 0, "R9 flags", DW'({link_err, switch_err}), '0);
        check(resp_valid == 0, "R9 resp_valid", DW'(resp_valid), '0);
        check(out_valid == '0, "R9 out_valid", DW'(out_valid), '0);
        rst_n = 1'b1;
        // R6 body before any head goes Local
        drive(1, mk(0, 3, 3), 0, '0, 0);
        // R5 head east, R6 body follows
        drive(1, mk(1, 3, 0), 0, '0, 0);
        drive(1, mk(0, 0, 0), 0, '0, 0);
        // R3 corrupt head toward west dropped, body still east
        drive(1, mk(1, 0, 2), 1, '0, 0);
        drive(1, mk(0, 0, 0), 0, '0, 0);
        // R8 clear
        drive(0, '0, 0, '0, 1);
        // R7 upset on clean flit, flag two cycles on
        drive(1, mk(1, 1, 2), 0, 64'h1 << 17, 0);
        drive(0, '0, 0, '0, 0);
        drive(0, '0, 0, '0, 0);
        // R8 set wins over clear
        drive(1, mk(1, 1, 3), 1, '0, 1);
        drive(0, '0, 0, '0, 1);
        // R5 each direction
        drive(1, mk(1, 1, 0), 0, '0, 0);
        drive(1, mk(1, 1, 3), 0, '0, 0);
        drive(1, mk(1, 1, 2), 0, '0, 0);
        drive(1, mk(1, 0, 3), 0, '0, 0);
        for (int i = 0; i < 3000; i++) begin
            bit v, bp, cl;
            logic [DW-1:0] up;
            v  = ($urandom % 4) != 0;
            bp = ($urandom % 8) == 0;
            cl = ($urandom % 20) == 0;
            up = (($urandom % 16) == 0) ? (64'h1 << ($urandom % 64)) : '0;
            drive(v, mk(($urandom % 3) == 0, $urandom % 4, $urandom % 4), bp, up, cl);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule